// File: doc/BRIEF.md
# Burst-Relative Event Timestamp Counter

This block assigns an identity to each accepted trigger in a beam that arrives in spills (bursts). A timestamp counter advances once per bunch-clock cycle and restarts at zero when a burst begins. Alongside it, a free-running fine-time phase counter divides the bunch clock by 2^FINE_W (256 by default) and flags the last cycle of every period. When a trigger is accepted inside a burst, the block captures the current timestamp and the event's sequence number within the burst, and pulses a valid flag for one cycle.

When the burst closes, the number of events accepted during it is latched into a holding register. A ready flag stays up until a downstream consumer acknowledges it. A synchronization pulse, sent to every unit at the same time, sets the timestamp, the event counter and the fine phase back to zero so that all units agree on the same timeline. The timestamp saturates at its maximum instead of wrapping, and a sticky flag records that it did.

Top module: `burst_evid_counter`

## Requirements
- R1: After reset, ts_now, fine_phase, cap_ts, cap_evt and eob_total are 0, and in_burst, ts_ovf, cap_valid, eob_ready and fine_tick are 0.
- R2: A burst_start pulse sets in_burst and makes ts_now 0 on the next cycle. While in_burst is 1, ts_now rises by one per cycle. Once the burst has ended, ts_now holds its value.
- R3: ts_now stops at 2^TS_W-1 instead of wrapping and ts_overflow (ts_ovf) becomes 1 and stays 1 until a burst_start or sync_pulse clears it.
- R4: fine_phase rises by one every cycle modulo 2^FINE_W. fine_tick is 1 exactly in the cycles where fine_phase equals 2^FINE_W-1.
- R5: A trig_accept that is high while in_burst is 1 gives cap_valid high for exactly one cycle on the next cycle. In that cycle cap_ts shows the ts_now value seen with the trigger, and cap_evt shows the number of triggers accepted earlier in the same burst, counted from 0. Triggers on consecutive cycles each produce a capture.
- R6: trig_accept is ignored when in_burst is 0, or when it arrives together with burst_start or sync_pulse. No capture occurs and the event total does not grow.
- R7: burst_end during a burst clears in_burst, loads eob_total with the number of events accepted in the burst (a trigger in the same cycle is included), and sets eob_ready. eob_ready stays 1 until evt_ack.
- R8: sync_pulse makes ts_now, fine_phase and the event count 0 on the next cycle and clears ts_ovf, but leaves in_burst unchanged.
- R9: When burst_end and evt_ack arrive in the same cycle, the new total is loaded and eob_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_start | input | 1 | Start-of-burst strobe |
| burst_end | input | 1 | End-of-burst strobe |
| trig_accept | input | 1 | Accepted-trigger strobe |
| sync_pulse | input | 1 | Counter realignment strobe |
| evt_ack | input | 1 | Acknowledge for the end-of-burst total |
| ts_now | output | TS_W | Bunch cycles since burst start |
| ts_ovf | output | 1 | Sticky timestamp saturation flag |
| fine_phase | output | FINE_W | Fine-time phase within the divided period |
| fine_tick | output | 1 | Last cycle of a fine-time period |
| in_burst | output | 1 | Burst currently open |
| cap_valid | output | 1 | One-cycle capture strobe |
| cap_ts | output | TS_W | Captured timestamp |
| cap_evt | output | EVT_W | Captured event number within the burst |
| eob_total | output | EVT_W | Events accepted in the last burst |
| eob_ready | output | 1 | eob_total is waiting to be acknowledged |

## Verification
A corrupted event counter is hidden until the next capture, where cap_evt shows the wrong value, or until the burst ends, where eob_total shows it. A wrong timestamp shows up at ts_now on the very next cycle, and again in cap_ts on the next trigger. Errors in the burst flag show up as captures that should not happen, or as missing ones. The bench therefore checks directly after each strobe and again a few cycles later, so that both immediate errors and errors that hold over time are seen.

// File: rtl/burst_evid_counter.sv
module burst_evid_counter #(
  parameter int TS_W   = 32,
  parameter int EVT_W  = 24,
  parameter int FINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_start,
  input  logic              burst_end,
  input  logic              trig_accept,
  input  logic              sync_pulse,
  input  logic              evt_ack,
  output logic [TS_W-1:0]   ts_now,
  output logic              ts_ovf,
  output logic [FINE_W-1:0] fine_phase,
  output logic              fine_tick,
  output logic              in_burst,
  output logic              cap_valid,
  output logic [TS_W-1:0]   cap_ts,
  output logic [EVT_W-1:0]  cap_evt,
  output logic [EVT_W-1:0]  eob_total,
  output logic              eob_ready
);

  localparam logic [TS_W-1:0]   TS_MAX   = '1;
  localparam logic [TS_W-1:0]   TS_ONE   = 1;
  localparam logic [EVT_W-1:0]  EVT_MAX  = '1;
  localparam logic [EVT_W-1:0]  EVT_ONE  = 1;
  localparam logic [FINE_W-1:0] FINE_ONE = 1;

  logic [EVT_W-1:0] evt_cnt;
  logic             restart;
  logic             take;
  logic             closing;
  logic [EVT_W-1:0] evt_next;

  assign restart   = burst_start | sync_pulse;
  assign take      = trig_accept & in_burst & ~restart;
  assign closing   = burst_end & in_burst & ~burst_start;
  assign evt_next  = (take && evt_cnt != EVT_MAX) ? evt_cnt + EVT_ONE : evt_cnt;
  assign fine_tick = &fine_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fine_phase <= '0;
    end else if (sync_pulse) begin
      fine_phase <= '0;
    end else begin
      fine_phase <= fine_phase + FINE_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_now  <= '0;
      ts_ovf  <= 1'b0;
      evt_cnt <= '0;
    end else if (restart) begin
      ts_now  <= '0;
      ts_ovf  <= 1'b0;
      evt_cnt <= '0;
    end else begin
      evt_cnt <= evt_next;
      if (in_burst) begin
        if (ts_now == TS_MAX) ts_ovf <= 1'b1;
        else                  ts_now <= ts_now + TS_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_burst <= 1'b0;
    end else if (burst_start) begin
      in_burst <= 1'b1;
    end else if (burst_end) begin
      in_burst <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_ts    <= '0;
      cap_evt   <= '0;
    end else begin
      cap_valid <= take;
      if (take) begin
        cap_ts  <= ts_now;
        cap_evt <= evt_cnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eob_total <= '0;
      eob_ready <= 1'b0;
    end else if (closing) begin
      eob_total <= evt_next;
      eob_ready <= 1'b1;
    end else if (evt_ack) begin
      eob_ready <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_evid_counter_chk.sv
module burst_evid_counter_chk #(
  parameter int TS_W   = 32,
  parameter int FINE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              burst_start,
  input logic              sync_pulse,
  input logic              trig_accept,
  input logic              evt_ack,
  input logic              burst_end,
  input logic [TS_W-1:0]   ts_now,
  input logic              ts_ovf,
  input logic [FINE_W-1:0] fine_phase,
  input logic              in_burst,
  input logic              cap_valid,
  input logic              eob_ready
);
  localparam logic [TS_W-1:0] TS_MAX = '1;
  localparam logic [TS_W-1:0] TS_ONE = 1;

  // R2
  ts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(burst_start) |-> (ts_now == '0 && in_burst));

  // R2
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_burst) && !$past(burst_start) && !$past(sync_pulse) && $past(ts_now) != TS_MAX)
      |-> ts_now == $past(ts_now) + TS_ONE);

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ts_ovf) && !$past(burst_start) && !$past(sync_pulse)) |-> ts_ovf);

  // R5
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> ($past(trig_accept) && $past(in_burst)));

  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(eob_ready) && !$past(evt_ack)) |-> eob_ready);

  // R9
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(burst_end) && $past(in_burst) && !$past(burst_start)) |-> eob_ready);

  // R8
  sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_pulse) |-> (ts_now == '0 && fine_phase == '0 && !ts_ovf));
endmodule

bind burst_evid_counter burst_evid_counter_chk #(.TS_W(TS_W), .FINE_W(FINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .sync_pulse(sync_pulse),
  .trig_accept(trig_accept), .evt_ack(evt_ack), .burst_end(burst_end),
  .ts_now(ts_now), .ts_ovf(ts_ovf), .fine_phase(fine_phase), .in_burst(in_burst),
  .cap_valid(cap_valid), .eob_ready(eob_ready)
);

// File: tb/burst_evid_counter_tb.sv
module burst_evid_counter_tb;
  localparam int TS_W = 8, EVT_W = 16, FINE_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic burst_start = 0, burst_end = 0, trig_accept = 0, sync_pulse = 0, evt_ack = 0;
  logic [TS_W-1:0] ts_now, cap_ts;
  logic [FINE_W-1:0] fine_phase;
  logic [EVT_W-1:0] cap_evt, eob_total;
  logic ts_ovf, fine_tick, in_burst, cap_valid, eob_ready;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  burst_evid_counter #(.TS_W(TS_W), .EVT_W(EVT_W), .FINE_W(FINE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .burst_end(burst_end),
    .trig_accept(trig_accept), .sync_pulse(sync_pulse), .evt_ack(evt_ack),
    .ts_now(ts_now), .ts_ovf(ts_ovf), .fine_phase(fine_phase), .fine_tick(fine_tick),
    .in_burst(in_burst), .cap_valid(cap_valid), .cap_ts(cap_ts), .cap_evt(cap_evt),
    .eob_total(eob_total), .eob_ready(eob_ready));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok || act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_burst();
    burst_start = 1; step(1); burst_start = 0;
  endtask

  task automatic close_burst();
    burst_end = 1; step(1); burst_end = 0;
  endtask

  task automatic t_reset();
    chk(1, "R1 ts", ts_now, 0);
    chk(1, "R1 flags", {ts_ovf, in_burst, cap_valid, eob_ready, fine_tick}, 0);
    chk(1, "R1 regs", {cap_ts, cap_evt, eob_total}, 0);
  endtask

  task automatic t_fine();
    sync_pulse = 1; step(1); sync_pulse = 0;
    chk(1, "R4 phase zero", fine_phase, 0);
    step(254);
    chk(1, "R4 phase 254", fine_phase, 254);
    chk(1, "R4 no tick", fine_tick, 0);
    step(1);
    chk(1, "R4 tick", fine_tick, 1);
    step(1);
    chk(1, "R4 wrap", {fine_phase, fine_tick}, 0);
  endtask

  task automatic t_count();
    logic [TS_W-1:0] held;
    open_burst();
    chk(1, "R2 cleared", ts_now, 0);
    chk(1, "R2 in_burst", in_burst, 1);
    step(10);
    chk(1, "R2 count", ts_now, 10);
    close_burst();
    held = ts_now;
    step(5);
    chk(1, "R2 hold", ts_now, held);
    chk(1, "R7 zero total", eob_total, 0);
    evt_ack = 1; step(1); evt_ack = 0;
    chk(1, "R7 ack", eob_ready, 0);
  endtask

  task automatic t_trig();
    open_burst();
    step(3);
    trig_accept = 1; step(1); trig_accept = 0;
    chk(1, "R5 valid", cap_valid, 1);
    chk(1, "R5 ts", cap_ts, 3);
    chk(1, "R5 evt", cap_evt, 0);
    step(1);
    chk(1, "R5 one cycle", cap_valid, 0);
    trig_accept = 1; step(1);
    chk(1, "R5 b2b ts", cap_ts, 5);
    chk(1, "R5 b2b evt", cap_evt, 1);
    step(1); trig_accept = 0;
    chk(1, "R5 b2b2 ts", cap_ts, 6);
    chk(1, "R5 b2b2 evt", {cap_valid, cap_evt}, {1'b1, 16'd2});
    step(2);
    trig_accept = 1; burst_end = 1; step(1); trig_accept = 0; burst_end = 0;
    chk(1, "R7 total", eob_total, 4);
    chk(1, "R7 ready", eob_ready, 1);
    chk(1, "R7 closed", in_burst, 0);
    step(3);
    chk(1, "R7 ready hold", eob_ready, 1);
    evt_ack = 1; step(1); evt_ack = 0;
    chk(1, "R7 ack clears", eob_ready, 0);
  endtask

  task automatic t_ignore();
    trig_accept = 1; step(1);
    chk(1, "R6 outside burst", cap_valid, 0);
    burst_start = 1; step(1); burst_start = 0; trig_accept = 0;
    chk(1, "R6 with start", cap_valid, 0);
    step(2);
    trig_accept = 1; sync_pulse = 1; step(1); trig_accept = 0; sync_pulse = 0;
    chk(1, "R6 with sync", cap_valid, 0);
    close_burst();
    chk(1, "R6 total", eob_total, 0);
  endtask

  task automatic t_end_ack();
    open_burst();
    trig_accept = 1; step(2); trig_accept = 0;
    burst_end = 1; evt_ack = 1; step(1); burst_end = 0; evt_ack = 0;
    chk(1, "R9 ready kept", eob_ready, 1);
    chk(1, "R9 total", eob_total, 2);
    evt_ack = 1; step(1); evt_ack = 0;
  endtask

  task automatic t_sync();
    open_burst();
    trig_accept = 1; step(1); trig_accept = 0;
    step(6);
    sync_pulse = 1; step(1); sync_pulse = 0;
    chk(1, "R8 ts", ts_now, 0);
    chk(1, "R8 phase", fine_phase, 0);
    chk(1, "R8 burst kept", in_burst, 1);
    step(4);
    chk(1, "R8 ts resume", ts_now, 4);
    trig_accept = 1; step(1); trig_accept = 0;
    chk(1, "R8 evt restart", cap_evt, 0);
    close_burst();
    chk(1, "R8 total", eob_total, 1);
    evt_ack = 1; step(1); evt_ack = 0;
  endtask

  task automatic t_ovf();
    open_burst();
    step(254);
    chk(1, "R3 below max", {ts_ovf, ts_now}, {1'b0, 8'd254});
    step(50);
    chk(1, "R3 saturate", ts_now, 255);
    chk(1, "R3 flag", ts_ovf, 1);
    step(3);
    chk(1, "R3 sticky", ts_ovf, 1);
    open_burst();
    chk(1, "R3 start clears", {ts_ovf, ts_now}, 0);
    step(300);
    sync_pulse = 1; step(1); sync_pulse = 0;
    chk(1, "R3 sync clears", ts_ovf, 0);
    close_burst();
    evt_ack = 1; step(1); evt_ack = 0;
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1;
    step(1);
    t_fine();
    t_count();
    t_trig();
    t_ignore();
    t_end_ack();
    t_sync();
    t_ovf();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule